// File: doc/BRIEF.md
# Bidirectional Multi-Lane Serial-to-Parallel Output Driver Core

This block is the digital core of a 96-channel serial-to-parallel output driver. Six separate 16-bit shift lanes load together on one clock, so each edge brings in six new bits, one per lane. A direction input picks which end of every lane takes serial data and which end gives the shifted-out bit back. The lane ports at both ends therefore come as separate input, output and drive-enable signals.

A latch enable copies all 96 shifted bits into a holding register. The held bits go through a global output stage, and that stage gives every channel a drive-enable bit and a level bit. Its global controls follow a fixed priority. Output enable low sets every channel to high impedance. Force-low comes next, then force-high, and last a polarity control that can invert the held data. A synchronous active-high reset clears both the lanes and the holding register.

Top module: `sp_driver_core`

## Requirements
- R1: Lane k (k = 0..5) owns the flat channel indices 16k through 16k+15, with lane position j at index 16k+j. A bit loaded into one lane never appears in another lane.
- R2: With `dir` = 0, at each rising clock edge every lane moves its bits up one position and loads `a_in[k]` at position 0. `b_out[k]` shows the current content of position 15, and `a_out[k]` reads 0.
- R3: With `dir` = 1, at each rising clock edge every lane moves its bits down one position and loads `b_in[k]` at position 15. `a_out[k]` shows the current content of position 0, and `b_out[k]` reads 0.
- R4: Exactly one end of each lane is an output. `a_oe` is all ones when `dir` = 1 and all zeros otherwise, and `b_oe` is always its complement.
- R5: On a rising edge with `le` = 1, the holding register takes the lane contents as they were before that edge's shift. With `le` = 0 it keeps its value.
- R6: When `rst` = 1 at a rising edge, all lane bits and all held bits become 0. While `rst` is 1, `a_out` and `b_out` read all zeros.
- R7: When `oe` = 0, every `ch_en` bit is 0 and every `ch_lvl` bit is 0, whatever the other controls and the held data are.
- R8: With `oe` = 1 and `force_lo_n` = 0, every channel has `ch_en` = 1 and `ch_lvl` = 0. This applies whatever `force_hi_n`, `pol` and the held data are.
- R9: With `oe` = 1, `force_lo_n` = 1 and `force_hi_n` = 0, every channel has `ch_en` = 1 and `ch_lvl` = 1, whatever `pol` and the held data are.
- R10: With `oe` = 1 and both force inputs at 1, every channel has `ch_en` = 1. Its `ch_lvl` equals the held bit when `pol` = 0 and the inverted held bit when `pol` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift and latch clock, rising edge |
| rst | input | 1 | Synchronous active-high clear |
| dir | input | 1 | Shift direction: 0 = A end to B end, 1 = B end to A end |
| le | input | 1 | Holding register load enable |
| oe | input | 1 | Output enable, 0 = all channels high impedance |
| force_lo_n | input | 1 | Active-low force of all channels to level 0 |
| force_hi_n | input | 1 | Active-low force of all channels to level 1 |
| pol | input | 1 | Invert the held data on the channels when 1 |
| a_in | input | 6 | Serial input at the A end of each lane |
| b_in | input | 6 | Serial input at the B end of each lane |
| a_out | output | 6 | Serial output at the A end of each lane |
| b_out | output | 6 | Serial output at the B end of each lane |
| a_oe | output | 6 | Drive enable for the A end of each lane |
| b_oe | output | 6 | Drive enable for the B end of each lane |
| ch_en | output | 96 | Per-channel drive enable |
| ch_lvl | output | 96 | Per-channel output level |

## Verification
A single marked bit pushed into one lane and then latched shows whether the channel mapping is right and whether the lanes stay apart. Random serial streams in each direction, with direction flips in the middle of a stream, separate a correct shift from a shift that uses the wrong end or the wrong input. They also catch a lane that gives back the wrong bit when it turns around. Random le patterns, including long runs with le held low, separate a correct hold from a load one edge early or late. A sweep of every combination of the four output controls over non-trivial held data checks the priority order and the polarity inversion.

// File: rtl/drvcore_pkg.sv
package drvcore_pkg;

    typedef enum logic [2:0] {
        DRV_OFF,
        DRV_LOW,
        DRV_HIGH,
        DRV_PASS,
        DRV_INV
    } drv_mode_e;

    // Priority: disable, then force-low, then force-high, then polarity
    function automatic drv_mode_e pick_mode(input logic en,
                                            input logic lo_n,
                                            input logic hi_n,
                                            input logic inv);
        if (!en)        return DRV_OFF;
        else if (!lo_n) return DRV_LOW;
        else if (!hi_n) return DRV_HIGH;
        else if (inv)   return DRV_INV;
        else            return DRV_PASS;
    endfunction

endpackage

// File: rtl/drv_shift_lane.sv
module drv_shift_lane #(
    parameter int LEN = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           dir,
    input  logic           ser_a_i,
    input  logic           ser_b_i,
    output logic           ser_a_o,
    output logic           ser_b_o,
    output logic [LEN-1:0] bits_o
);

    typedef struct packed {
        logic [LEN-1:0] sr;
    } lane_state_t;

    lane_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.sr = '0;
        end else if (!dir) begin
            st_d.sr = {st_q.sr[LEN-2:0], ser_a_i};
        end else begin
            st_d.sr = {ser_b_i, st_q.sr[LEN-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // the end that is not an input returns the bit about to leave
    assign ser_b_o = !rst && !dir && st_q.sr[LEN-1];
    assign ser_a_o = !rst &&  dir && st_q.sr[0];
    assign bits_o  = st_q.sr;

endmodule

// File: rtl/drv_hold_latch.sv
module drv_hold_latch #(
    parameter int W = 96
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         le,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] data_o
);

    typedef struct packed {
        logic [W-1:0] held;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.held = '0;
        end else if (le) begin
            st_d.held = data_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign data_o = st_q.held;

endmodule

// File: rtl/drv_out_stage.sv
module drv_out_stage
    import drvcore_pkg::*;
#(
    parameter int W = 96
) (
    input  logic         oe,
    input  logic         force_lo_n,
    input  logic         force_hi_n,
    input  logic         pol,
    input  logic [W-1:0] held_i,
    output logic [W-1:0] en_o,
    output logic [W-1:0] lvl_o
);

    drv_mode_e mode;

    always_comb begin
        mode = pick_mode(oe, force_lo_n, force_hi_n, pol);
        unique case (mode)
            DRV_OFF:  begin en_o = '0; lvl_o = '0;      end
            DRV_LOW:  begin en_o = '1; lvl_o = '0;      end
            DRV_HIGH: begin en_o = '1; lvl_o = '1;      end
            DRV_INV:  begin en_o = '1; lvl_o = ~held_i; end
            default:  begin en_o = '1; lvl_o = held_i;  end
        endcase
    end

endmodule

// File: rtl/sp_driver_core.sv
module sp_driver_core #(
    parameter int NUM_LANES = 6,
    parameter int LANE_LEN  = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            dir,
    input  logic                            le,
    input  logic                            oe,
    input  logic                            force_lo_n,
    input  logic                            force_hi_n,
    input  logic                            pol,
    input  logic [NUM_LANES-1:0]            a_in,
    input  logic [NUM_LANES-1:0]            b_in,
    output logic [NUM_LANES-1:0]            a_out,
    output logic [NUM_LANES-1:0]            b_out,
    output logic [NUM_LANES-1:0]            a_oe,
    output logic [NUM_LANES-1:0]            b_oe,
    output logic [NUM_LANES*LANE_LEN-1:0]   ch_en,
    output logic [NUM_LANES*LANE_LEN-1:0]   ch_lvl
);

    localparam int NCH = NUM_LANES * LANE_LEN;

    logic [NCH-1:0] sr_all;
    logic [NCH-1:0] lat_all;

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        drv_shift_lane #(.LEN(LANE_LEN)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .dir     (dir),
            .ser_a_i (a_in[k]),
            .ser_b_i (b_in[k]),
            .ser_a_o (a_out[k]),
            .ser_b_o (b_out[k]),
            .bits_o  (sr_all[k*LANE_LEN +: LANE_LEN])
        );
    end

    assign a_oe = {NUM_LANES{dir}};
    assign b_oe = {NUM_LANES{~dir}};

    drv_hold_latch #(.W(NCH)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .le     (le),
        .data_i (sr_all),
        .data_o (lat_all)
    );

    drv_out_stage #(.W(NCH)) u_out (
        .oe         (oe),
        .force_lo_n (force_lo_n),
        .force_hi_n (force_hi_n),
        .pol        (pol),
        .held_i     (lat_all),
        .en_o       (ch_en),
        .lvl_o      (ch_lvl)
    );

endmodule

// File: rtl/sp_driver_chk.sv
module sp_driver_chk #(
    parameter int NUM_LANES = 6,
    parameter int LANE_LEN  = 16
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          dir,
    input logic                          le,
    input logic                          oe,
    input logic                          force_lo_n,
    input logic                          force_hi_n,
    input logic [NUM_LANES-1:0]          a_out,
    input logic [NUM_LANES-1:0]          b_out,
    input logic [NUM_LANES-1:0]          a_oe,
    input logic [NUM_LANES-1:0]          b_oe,
    input logic [NUM_LANES*LANE_LEN-1:0] ch_en,
    input logic [NUM_LANES*LANE_LEN-1:0] ch_lvl,
    input logic [LANE_LEN-1:0]           lane0,
    input logic [NUM_LANES*LANE_LEN-1:0] held
);

    // R2
    up_shift_chk: assert property (@(posedge clk) disable iff (rst)
        !dir |=> lane0[LANE_LEN-1:1] == $past(lane0[LANE_LEN-2:0]));

    // R3
    down_shift_chk: assert property (@(posedge clk) disable iff (rst)
        dir |=> lane0[LANE_LEN-2:0] == $past(lane0[LANE_LEN-1:1]));

    // R4
    port_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (a_oe ^ b_oe) == {NUM_LANES{1'b1}});

    // R5
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !le |=> $stable(held));

    // R6
    always_comb begin
        if (rst) begin
            serial_quiet_chk: assert ((a_out | b_out) == '0);
        end
    end

    // R7
    hiz_all_chk: assert property (@(posedge clk) disable iff (rst)
        !oe |-> (ch_en == '0 && ch_lvl == '0));

    // R8
    force_low_chk: assert property (@(posedge clk) disable iff (rst)
        (oe && !force_lo_n) |-> (ch_en == '1 && ch_lvl == '0));

    // R9
    force_high_chk: assert property (@(posedge clk) disable iff (rst)
        (oe && force_lo_n && !force_hi_n) |-> (ch_en == '1 && ch_lvl == '1));

endmodule

bind sp_driver_core sp_driver_chk #(
    .NUM_LANES (NUM_LANES),
    .LANE_LEN  (LANE_LEN)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .dir        (dir),
    .le         (le),
    .oe         (oe),
    .force_lo_n (force_lo_n),
    .force_hi_n (force_hi_n),
    .a_out      (a_out),
    .b_out      (b_out),
    .a_oe       (a_oe),
    .b_oe       (b_oe),
    .ch_en      (ch_en),
    .ch_lvl     (ch_lvl),
    .lane0      (sr_all[LANE_LEN-1:0]),
    .held       (lat_all)
);

// File: tb/sp_driver_core_test.sv
`timescale 1ns/1ps
module sp_driver_core_test;

    localparam int NL = 6;
    localparam int LL = 16;
    localparam int NC = NL * LL;

    logic clk = 1'b0;
    logic rst = 1'b1, dir = 1'b0, le = 1'b0, oe = 1'b1;
    logic force_lo_n = 1'b1, force_hi_n = 1'b1, pol = 1'b0;
    logic [NL-1:0] a_in = '0, b_in = '0;
    logic [NL-1:0] a_out, b_out, a_oe, b_oe;
    logic [NC-1:0] ch_en, ch_lvl;

    int checks = 0;
    int errors = 0;

    bit m_sr  [NL][LL];
    bit m_lat [NC];

    always #5 clk = ~clk;

    sp_driver_core #(.NUM_LANES(NL), .LANE_LEN(LL)) uut (
        .clk(clk), .rst(rst), .dir(dir), .le(le), .oe(oe),
        .force_lo_n(force_lo_n), .force_hi_n(force_hi_n), .pol(pol),
        .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
        .a_oe(a_oe), .b_oe(b_oe), .ch_en(ch_en), .ch_lvl(ch_lvl)
    );

    task automatic check_vec(input string tag, input logic [NC-1:0] act,
                             input logic [NC-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            foreach (m_sr[k, j]) m_sr[k][j] = 1'b0;
            foreach (m_lat[i]) m_lat[i] = 1'b0;
        end else begin
            if (le) foreach (m_lat[i]) m_lat[i] = m_sr[i / LL][i % LL];
            for (int k = 0; k < NL; k++) begin
                if (!dir) begin
                    for (int j = LL - 1; j > 0; j--) m_sr[k][j] = m_sr[k][j-1];
                    m_sr[k][0] = a_in[k];
                end else begin
                    for (int j = 0; j < LL - 1; j++) m_sr[k][j] = m_sr[k][j+1];
                    m_sr[k][LL-1] = b_in[k];
                end
            end
        end
    endtask

    task automatic compare_all();
        logic [NC-1:0] e_en, e_lvl;
        logic [NC-1:0] e_a, e_b, e_aoe, e_boe;
        string ctag, stag;
        e_a = '0; e_b = '0;
        for (int k = 0; k < NL; k++) begin
            e_a[k] = !rst && dir && m_sr[k][0];
            e_b[k] = !rst && !dir && m_sr[k][LL-1];
        end
        stag = rst ? "R6 serial" : (dir ? "R3 serial" : "R2 serial");
        check_vec({stag, " a_out"}, NC'(a_out), e_a);
        check_vec({stag, " b_out"}, NC'(b_out), e_b);
        e_aoe = dir ? NC'({NL{1'b1}}) : '0;
        e_boe = dir ? '0 : NC'({NL{1'b1}});
        check_vec("R4 a_oe", NC'(a_oe), e_aoe);
        check_vec("R4 b_oe", NC'(b_oe), e_boe);
        for (int i = 0; i < NC; i++) begin
            if (!oe)              begin e_en[i] = 0; e_lvl[i] = 0; end
            else if (!force_lo_n) begin e_en[i] = 1; e_lvl[i] = 0; end
            else if (!force_hi_n) begin e_en[i] = 1; e_lvl[i] = 1; end
            else                  begin e_en[i] = 1; e_lvl[i] = m_lat[i] ^ pol; end
        end
        ctag = !oe ? "R7" : (!force_lo_n ? "R8" : (!force_hi_n ? "R9" : "R10/R5"));
        check_vec({ctag, " ch_en"}, ch_en, e_en);
        check_vec({ctag, " ch_lvl"}, ch_lvl, e_lvl);
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [NC-1:0] snap;
        // R6: reset clears state
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check_vec("R6 cleared levels", ch_lvl, '0);

        // R1: one marked bit into lane 1 lands at flat index 16 only
        a_in = 6'b000010;
        tick();
        a_in = '0; le = 1'b1;
        tick();
        le = 1'b0;
        check_vec("R1 lane map", ch_lvl, NC'(1) << 16);

        // R2: random streams upward, random latching
        for (int n = 0; n < 60; n++) begin
            a_in = NL'($urandom); b_in = NL'($urandom); le = ($urandom % 4) == 0;
            tick();
        end
        // R3: downward, with direction flips
        dir = 1'b1;
        for (int n = 0; n < 60; n++) begin
            a_in = NL'($urandom); b_in = NL'($urandom); le = ($urandom % 3) == 0;
            if (n % 17 == 16) dir = ~dir;
            tick();
        end

        // R5: hold with le low over many edges
        le = 1'b1; tick(); le = 1'b0;
        snap = ch_lvl;
        for (int n = 0; n < 20; n++) begin
            a_in = NL'($urandom); b_in = NL'($urandom);
            tick();
        end
        check_vec("R5 hold", ch_lvl, snap);

        // R7..R10: sweep output controls
        for (int c = 0; c < 16; c++) begin
            {oe, force_lo_n, force_hi_n, pol} = 4'(c);
            a_in = NL'($urandom); b_in = NL'($urandom); le = c[0];
            tick();
            tick();
        end
        {oe, force_lo_n, force_hi_n, pol} = 4'b1110;

        // R6: reset in the middle of traffic
        for (int n = 0; n < 10; n++) begin
            a_in = '1; b_in = '1; le = 1'b1; tick();
        end
        rst = 1'b1; tick(); tick();
        rst = 1'b0; le = 1'b1; a_in = '0; b_in = '0;
        tick();
        check_vec("R6 post-reset latch", ch_lvl, '0);
        summary();
    end

endmodule